// File: doc/BRIEF.md
# HDLC Bit-Stuffing Frame Transmitter

This block turns a stream of octets into a synchronous HDLC bit stream, producing one line bit for each cycle in which the clock-enable strobe `bit_en` is high. Between frames the line carries complete flags (octet 0x7E) placed back to back. A byte source offers address, control and information octets over a valid/ready handshake and marks the final octet with `in_last`. The transmitter takes the first octet at the end of a flag, which then serves as the opening flag. It sends every octet least significant bit first and inserts a zero after any five consecutive ones. It then appends the complemented 16-bit CRC of the payload and closes the frame with a flag.

A frame can be abandoned with `abort_req`. The block then drops the frame at once and sends a run of unstuffed ones, with no FCS and no closing flag. The same abort happens automatically when the source has no octet ready in time in the middle of a frame. Holding `idle_req` replaces flag fill with a long run of ones that marks the link as idle.

Top module: `hdlc_tx_framer`

## Requirements
- R1: `tx_bit` changes only on a clock edge where `bit_en` is high, and each such edge emits exactly one new line bit.
- R2: With no frame in progress the line carries whole flags, sent as the bits 0,1,1,1,1,1,1,0. Adjacent flags never share a zero.
- R3: An octet is taken (`in_valid` and `in_ready` both high) only on the strobe that emits the last bit of a flag or the last data bit of a non-final octet. Octets go out least significant bit first.
- R4: After five consecutive ones in the payload or FCS, a 0 bit is inserted. This also applies across octet boundaries and just before the closing flag, so no flag pattern appears inside a frame.
- R5: The CRC register is preset to 0xFFFF when the first octet is taken. For each unstuffed payload bit it advances with feedback = bit15 XOR data bit and polynomial 0x1021. Flags and stuffed zeros are excluded.
- R6: After the final octet the ones complement of the CRC goes out as 16 bits, bit 15 first, with stuffing. A closing flag follows at once, and that flag may open the next frame.
- R7: `in_ready` is high only during a cycle with `bit_en` high. It is low while a stuffed zero, an FCS bit or any flag bit other than the last is being output.
- R8: A strobe with `abort_req` high during a frame emits a 1 at once, followed by 7 further ones. No FCS or closing flag is sent, and flag fill then resumes.
- R9: If a non-final octet finishes while `in_valid` is low, the frame is aborted with 7 ones, and flag fill resumes.
- R10: If `idle_req` is high at the end of a flag or at the end of an abort, the line carries ones: at least 15 in a row, and continuing while `idle_req` stays high. Flags follow.
- R11: During and after reset `tx_bit` is 1 and `in_ready` is 0 until the first strobe. The first strobe starts a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit strobe: one line bit per high cycle |
| in_valid | input | 1 | Octet offered by the source |
| in_data | input | 8 | Octet value |
| in_last | input | 1 | Offered octet is the final one of the frame |
| in_ready | output | 1 | Octet taken on this clock edge when `in_valid` is high |
| abort_req | input | 1 | Abandon the frame in progress |
| idle_req | input | 1 | Send idle ones instead of flag fill |
| tx_bit | output | 1 | Serial line bit |

## Verification
The assertions check, on every cycle, several local rules. The line bit holds between strobes. A stuffed zero follows whenever the run of five ones is due. The handshake opens only on strobes in the flag or data phase. An abort strobe yields a one and the abort state. The CRC register reads all ones after a preset. The ordering across a whole frame can only be shown by the bench, which decodes the serial stream with its own receiver and compares each decoded frame against the queued octets. That ordering covers octet values and bit order, FCS value and order, flag spacing without shared zeros, abort and idle run lengths, and back-to-back frames.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FLAG  = 3'd0,
        ST_DATA  = 3'd1,
        ST_FCS   = 3'd2,
        ST_PAD   = 3'd3,
        ST_ABORT = 3'd4,
        ST_IDLE  = 3'd5
    } tx_state_e;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int          WIDTH  = 16,
    parameter logic [WIDTH-1:0] POLY   = 16'h1021,
    parameter logic [WIDTH-1:0] PRESET = 16'hFFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic feed,
    input  logic din,
    input  logic drain,
    output logic msb
);

    logic [WIDTH-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[WIDTH-1] ^ din;
        if (preset) begin
            crc_d = PRESET;
        end else if (feed) begin
            crc_d = {crc_q[WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (drain) begin
            crc_d = {crc_q[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= PRESET;
        else        crc_q <= crc_d;
    end

    assign msb = crc_q[WIDTH-1];

    // R5: the register holds the all-ones preset right after a frame start
    assert_crc_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (crc_q == PRESET));

endmodule

// File: rtl/hdlc_tx_ones.sv
module hdlc_tx_ones #(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_in,
    output logic stuff_due
);

    localparam int RW = $clog2(STUFF_RUN + 2);
    localparam logic [RW-1:0] RUN_LIMIT = RW'(STUFF_RUN);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (clear)       run_d = '0;
        else if (step)   run_d = bit_in ? run_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign stuff_due = (run_q == RUN_LIMIT);

    // R4: once five ones have gone out, the next stepped bit must be a zero
    assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && stuff_due && !clear) |-> !bit_in);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int ABORT_ONES = 7,
    parameter int IDLE_MIN   = 15,
    parameter int STUFF_RUN  = 5,
    parameter int FCS_BITS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       abort_req,
    input  logic       idle_req,
    output logic       tx_bit
);

    localparam int CNT_MAX = (IDLE_MIN > FCS_BITS) ? IDLE_MIN : FCS_BITS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LAST_BIT   = CW'(7);
    localparam logic [CW-1:0] LAST_FCS   = CW'(FCS_BITS - 1);
    localparam logic [CW-1:0] LAST_ABORT = CW'(ABORT_ONES - 1);
    localparam logic [CW-1:0] LAST_IDLE  = CW'(IDLE_MIN - 1);

    typedef struct packed {
        tx_state_e   state;
        logic [CW-1:0] cnt;
        logic [7:0]  shreg;
        logic        last;
        logic        tx;
    } regs_t;

    regs_t r_d, r_q;

    logic ready;
    logic crc_preset, crc_feed, crc_drain, crc_bit, crc_msb;
    logic ones_clear, ones_step, ones_bit, stuff_due;
    logic in_body;

    hdlc_tx_crc #(
        .WIDTH (FCS_BITS),
        .POLY  (CRC_POLY),
        .PRESET(CRC_PRESET)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .preset(crc_preset),
        .feed  (crc_feed),
        .din   (crc_bit),
        .drain (crc_drain),
        .msb   (crc_msb)
    );

    hdlc_tx_ones #(
        .STUFF_RUN(STUFF_RUN)
    ) u_ones (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ones_clear),
        .step     (ones_step),
        .bit_in   (ones_bit),
        .stuff_due(stuff_due)
    );

    assign in_body = (r_q.state == ST_DATA) || (r_q.state == ST_FCS) ||
                     (r_q.state == ST_PAD);

    always_comb begin
        r_d        = r_q;
        ready      = 1'b0;
        crc_preset = 1'b0;
        crc_feed   = 1'b0;
        crc_drain  = 1'b0;
        crc_bit    = 1'b0;
        ones_clear = 1'b0;
        ones_step  = 1'b0;
        ones_bit   = 1'b0;

        if (bit_en) begin
            if (in_body && abort_req) begin
                r_d.tx    = 1'b1;
                r_d.state = ST_ABORT;
                r_d.cnt   = '0;
            end else begin
                case (r_q.state)
                    ST_FLAG: begin
                        r_d.tx = FLAG_OCTET[r_q.cnt[2:0]];
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.cnt = '0;
                            if (idle_req) begin
                                r_d.state = ST_IDLE;
                            end else begin
                                ready = 1'b1;
                                if (in_valid) begin
                                    r_d.shreg  = in_data;
                                    r_d.last   = in_last;
                                    r_d.state  = ST_DATA;
                                    crc_preset = 1'b1;
                                    ones_clear = 1'b1;
                                end
                            end
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        ones_step = 1'b1;
                        if (stuff_due) begin
                            r_d.tx   = 1'b0;
                            ones_bit = 1'b0;
                        end else begin
                            r_d.tx    = r_q.shreg[0];
                            ones_bit  = r_q.shreg[0];
                            crc_feed  = 1'b1;
                            crc_bit   = r_q.shreg[0];
                            r_d.shreg = {1'b0, r_q.shreg[7:1]};
                            if (r_q.cnt == LAST_BIT) begin
                                r_d.cnt = '0;
                                if (r_q.last) begin
                                    r_d.state = ST_FCS;
                                end else begin
                                    ready = 1'b1;
                                    if (in_valid) begin
                                        r_d.shreg = in_data;
                                        r_d.last  = in_last;
                                    end else begin
                                        r_d.state = ST_ABORT;
                                    end
                                end
                            end else begin
                                r_d.cnt = r_q.cnt + 1'b1;
                            end
                        end
                    end
                    ST_FCS: begin
                        ones_step = 1'b1;
                        if (stuff_due) begin
                            r_d.tx   = 1'b0;
                            ones_bit = 1'b0;
                        end else begin
                            r_d.tx    = ~crc_msb;
                            ones_bit  = ~crc_msb;
                            crc_drain = 1'b1;
                            if (r_q.cnt == LAST_FCS) begin
                                r_d.cnt   = '0;
                                r_d.state = ST_PAD;
                            end else begin
                                r_d.cnt = r_q.cnt + 1'b1;
                            end
                        end
                    end
                    ST_PAD: begin
                        // a leading zero: either the owed stuff bit or flag bit 0
                        r_d.tx     = 1'b0;
                        ones_clear = 1'b1;
                        r_d.state  = ST_FLAG;
                        r_d.cnt    = stuff_due ? '0 : CW'(1);
                    end
                    ST_ABORT: begin
                        r_d.tx = 1'b1;
                        if (r_q.cnt == LAST_ABORT) begin
                            r_d.cnt   = '0;
                            r_d.state = idle_req ? ST_IDLE : ST_FLAG;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                    ST_IDLE: begin
                        r_d.tx = 1'b1;
                        if (r_q.cnt != LAST_IDLE) begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end else if (!idle_req) begin
                            r_d.cnt   = '0;
                            r_d.state = ST_FLAG;
                        end
                    end
                    default: begin
                        r_d.state = ST_FLAG;
                        r_d.cnt   = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_FLAG;
            r_q.cnt   <= '0;
            r_q.shreg <= '0;
            r_q.last  <= 1'b0;
            r_q.tx    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_bit   = r_q.tx;
    assign in_ready = ready;

    // R1: the line bit holds on cycles without a strobe
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R7: the handshake opens only on strobes in the flag or data phase
    assert_ready_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bit_en && (r_q.state == ST_FLAG || r_q.state == ST_DATA)));

    // R4: a due stuff bit inside the frame body goes out as a zero
    assert_body_stuff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_due && !abort_req &&
         (r_q.state == ST_DATA || r_q.state == ST_FCS)) |=> !tx_bit);

    // R8: an abort strobe inside a frame emits a one and enters the abort run
    assert_abort_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && abort_req && in_body) |=> (tx_bit && r_q.state == ST_ABORT));

endmodule

// File: tb/hdlc_tx_framer_test.sv
`timescale 1ns/1ps
module hdlc_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       abort_req = 1'b0;
    logic       idle_req = 1'b0;
    logic       tx_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hdlc_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .abort_req(abort_req), .idle_req(idle_req), .tx_bit(tx_bit)
    );

    // scoreboard queues
    logic [7:0] kindq[$];
    int         lenq[$];
    logic [7:0] byteq[$];

    // strobe generator
    logic [15:0] lfsr = 16'hACE1;
    bit          en_on = 1'b0;
    always @(negedge clk) begin
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_en <= en_on && (lfsr[1:0] != 2'b00);
    end

    logic en_seen = 1'b0;
    logic accepted = 1'b0;
    always @(posedge clk) begin
        en_seen  <= bit_en;
        accepted <= in_valid && in_ready;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        crc_step = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // receiver model
    int   run = 0;
    int   nbits = 0;
    int   flags_seen = 0;
    bit   pend_idle = 1'b0;
    logic bitbuf [0:4095];
    logic prev_tx = 1'b1;
    bit   mon_on = 1'b0;

    task automatic frame_done(input int nb);
        logic [7:0]  k;
        int          len;
        logic [15:0] crc;
        logic [15:0] rx_fcs;
        logic [7:0]  rb, eb;
        if (kindq.size() == 0) begin
            check(0, "R6", "unexpected frame bytes", nb, 0);
            return;
        end
        k = kindq.pop_front();
        check(k == "G", "R6", "frame completed where abort/idle expected", k, "G");
        if (k != "G") return;
        len = lenq.pop_front();
        check(nb == len + 2, "R6", "frame length incl FCS", nb, len + 2);
        crc = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            eb = byteq.pop_front();
            for (int j = 0; j < 8; j++) begin
                rb[j] = bitbuf[i*8+j];
                crc = crc_step(crc, eb[j]);
            end
            check(rb == eb, "R3", "octet value LSB first", rb, eb);
        end
        if (nb == len + 2) begin
            for (int q = 0; q < 16; q++) rx_fcs[15-q] = bitbuf[len*8+q];
            check(rx_fcs == ~crc, "R5", "FCS equals complemented CRC, MSB first",
                  rx_fcs, ~crc);
        end
    endtask

    task automatic rx_bit(input logic b);
        logic [7:0] k;
        if (b) begin
            run++;
            if (run <= 6 && nbits < 4096) begin bitbuf[nbits] = 1'b1; nbits++; end
            if (run == 7) begin
                nbits = 0;
                if (kindq.size() == 0) begin
                    check(0, "R8", "unexpected run of seven ones", run, 0);
                    pend_idle = 1'b0;
                end else begin
                    k = kindq.pop_front();
                    check(k != "G", "R8", "ones run inside a good frame", k, "G");
                    if (k == "G") begin
                        int l = lenq.pop_front();
                        for (int i = 0; i < l; i++) void'(byteq.pop_front());
                    end
                    pend_idle = (k == "I");
                end
            end
        end else begin
            if (run >= 7) begin
                if (pend_idle)
                    check(run >= 15, "R10", "idle run length", run, 15);
                else
                    check(run >= 7 && run < 15, "R8", "abort run length", run, 7);
                pend_idle = 1'b0;
            end
            if (run == 6) begin
                flags_seen++;
                check(nbits >= 7 && ((nbits - 7) % 8) == 0, "R2",
                      "whole flags with no shared zero", nbits, 7);
                if (nbits > 7) frame_done((nbits - 7) / 8);
                nbits = 0;
            end else if (run != 5) begin
                if (nbits < 4096) begin bitbuf[nbits] = 1'b0; nbits++; end
            end
            run = 0;
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (en_seen) begin
                rx_bit(tx_bit);
            end else if (tx_bit !== prev_tx) begin
                check(0, "R1", "line bit changed without strobe", tx_bit, prev_tx);
            end
            if (in_ready)
                check(bit_en, "R7", "ready only during a strobe", bit_en, 1);
            prev_tx = tx_bit;
        end
    end

    logic [7:0] pay [0:63];

    // mode 0 normal, 1 abort_req after cut octets, 2 underrun, 3 abort then idle
    task automatic send_frame(input int n, input int mode, input int cut);
        if (mode == 0) begin
            kindq.push_back("G");
            lenq.push_back(n);
            for (int i = 0; i < n; i++) byteq.push_back(pay[i]);
        end else if (mode == 3) begin
            kindq.push_back("I");
        end else begin
            kindq.push_back("A");
        end
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = pay[i];
            in_last  = (mode == 0) && (i == n - 1);
            do @(negedge clk); while (!accepted);
            if ((mode == 1 || mode == 3) && i + 1 == cut) begin
                in_valid  = 1'b0;
                in_last   = 1'b0;
                abort_req = 1'b1;
                if (mode == 3) idle_req = 1'b1;
                do @(negedge clk); while (!en_seen);
                abort_req = 1'b0;
                if (mode == 3) begin
                    repeat (40) @(negedge clk);
                    idle_req = 1'b0;
                end
                return;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        while (kindq.size() != 0) @(negedge clk);
        repeat (120) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_bit == 1'b1, "R11", "line bit in reset", tx_bit, 1);
        check(in_ready == 1'b0, "R11", "ready in reset", in_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_bit == 1'b1, "R11", "line bit after reset before strobe", tx_bit, 1);
        check(in_ready == 1'b0, "R11", "ready after reset before strobe", in_ready, 0);
        mon_on = 1'b1;
        en_on  = 1'b1;
        repeat (60) @(negedge clk);
        check(flags_seen >= 2, "R2", "flag fill while idle", flags_seen, 2);

        // short frame, mixed bits (R3, R5, R6)
        pay[0] = 8'h03; pay[1] = 8'hC0; pay[2] = 8'h55;
        send_frame(3, 0, 0);
        drain();

        // stuffing across octet boundaries and into the FCS (R4)
        pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'h3F; pay[4] = 8'hF8;
        send_frame(5, 0, 0);
        drain();

        // single zero octet
        pay[0] = 8'h00;
        send_frame(1, 0, 0);
        drain();

        // longer computed payload
        for (int i = 0; i < 20; i++) pay[i] = 8'(i * 37 + 11);
        send_frame(20, 0, 0);
        drain();

        // back-to-back frames sharing one flag (R6)
        pay[0] = 8'hA5; pay[1] = 8'h1F;
        send_frame(2, 0, 0);
        pay[0] = 8'hF0; pay[1] = 8'h0F; pay[2] = 8'hE7;
        send_frame(3, 0, 0);
        drain();

        // requested abort (R8)
        for (int i = 0; i < 6; i++) pay[i] = 8'(8'hF3 ^ i);
        send_frame(6, 1, 2);
        drain();

        // underrun abort (R9)
        for (int i = 0; i < 3; i++) pay[i] = 8'(8'h5A + i);
        send_frame(3, 2, 0);
        drain();

        // recovery frame after abort
        pay[0] = 8'h81; pay[1] = 8'h7E;
        send_frame(2, 0, 0);
        drain();

        // abort followed by idle (R8, R10)
        for (int i = 0; i < 4; i++) pay[i] = 8'(8'h3C + i);
        send_frame(4, 3, 1);
        drain();

        // idle between frames (R10)
        kindq.push_back("I");
        idle_req = 1'b1;
        repeat (60) @(negedge clk);
        idle_req = 1'b0;
        drain();

        // frame after idle
        pay[0] = 8'hC3;
        send_frame(1, 0, 0);
        drain();

        check(kindq.size() == 0, "R6", "all expected events observed", kindq.size(), 0);
        finish_run();
    end

endmodule